// File: doc/BRIEF.md
# I2C Multi-Master Arbitration and Collision Monitor

This block runs beside an I2C master sequencer. It watches the synchronized SDA and SCL samples and detects when the master loses arbitration. That happens when the master releases SDA, expecting a 1, while another device holds the line low during an SCL-high window. It also tracks Start and Stop conditions on the bus, so the master can tell when the bus is free to claim.

When a collision is seen, the block emits a one-cycle response:

- a master interrupt pulse;
- an abort request that sends the master back to idle;
- a forced release of both lines;
- a clear strobe for the transmit-buffer-full flag, if a byte was being sent;
- clear strobes for whichever Start, Restart, Stop or Acknowledge control bits were active.

After a lost arbitration, the block keeps monitoring the bus and raises the interrupt again when the next Stop appears. The master's next transmit then begins at the first data bit.

A rising sleep request aborts any transfer in progress. When the stop-in-idle control is set, an idle request freezes the monitor.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset all pulse outputs are 0, `s_flag` and `p_flag` are 0, and `bus_free` is 1.
- R2: A Start (SDA sampled 1 then 0 while SCL is sampled high on both cycles) sets `s_flag` and clears `p_flag` one clock later.
- R3: A Stop (SDA sampled 0 then 1 while SCL is sampled high on both cycles) sets `p_flag` and clears `s_flag` one clock later.
- R4: `bus_free` is 1 when `p_flag` is 1 or when both flags are 0, and 0 otherwise.
- R5: A collision occurs when all of the following hold in the same sample:
  - the master is active, meaning `tx_busy` is set or any `cond_busy` bit is set;
  - `sda_drive` is 1;
  - `sda_in` is 0;
  - SCL has been high for more than HOLD consecutive samples.

  On a collision, `mst_irq`, `mst_abort` and `force_release` each pulse for one cycle, one clock later.
- R6: The first HOLD samples after SCL goes high (default 1) never produce a collision.
- R7: `tbf_clr` pulses together with the abort only if `tx_busy` was 1 at the collision.
- R8: `cond_clr` pulses, together with the abort, a copy of `cond_busy` at the collision. The bits are: bit 0 Start, bit 1 Restart, bit 2 Stop, bit 3 Acknowledge.
- R9: After a collision, the next detected Stop pulses `mst_irq` without `mst_abort`, and does so only once.
- R10: A rising edge of `sleep_req` while `tx_busy`, `rx_busy` or any `cond_busy` bit is set pulses `mst_abort`, `force_release` and the clear strobes without `mst_irq`. A held `sleep_req` does not repeat the pulse.
- R11: While `idle_req` and `stop_in_idle` are both 1, no Start, Stop or collision is detected and the flags hold. With `stop_in_idle` at 0, `idle_req` has no effect.
- R12: No collision occurs when `sda_drive` is 0 or when the master is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Synchronized SDA sample |
| scl_in | input | 1 | Synchronized SCL sample |
| sda_drive | input | 1 | Value the master intends on SDA (1 = released) |
| tx_busy | input | 1 | Master is transmitting a byte |
| rx_busy | input | 1 | Master is receiving a byte |
| cond_busy | input | 4 | Active condition: bit0 Start, bit1 Restart, bit2 Stop, bit3 Ack |
| sleep_req | input | 1 | Sleep request |
| idle_req | input | 1 | Idle request |
| stop_in_idle | input | 1 | 1 = freeze the monitor during idle |
| mst_irq | output | 1 | Master event interrupt pulse |
| mst_abort | output | 1 | Return-to-idle request pulse |
| force_release | output | 1 | Release SDA and SCL pulse |
| tbf_clr | output | 1 | Clear the transmit-buffer-full flag |
| cond_clr | output | 4 | Clear strobes for the condition control bits |
| s_flag | output | 1 | Start seen last |
| p_flag | output | 1 | Stop seen last |
| bus_free | output | 1 | Bus may be claimed |

## Verification
A collision and a Start detection can fall in the same cycle. This happens when another master pulls SDA low while SCL has been high for a while and this master is releasing SDA during a transfer. The bench provokes it by holding SCL high long enough for the hold window to pass, keeping `tx_busy` and `sda_drive` at 1, and then dropping `sda_in`. One clock later it expects the abort pulse together with `s_flag` set and `bus_free` low. The random phase compares every output on every cycle against a behavioural model in the bench, which reaches the same overlap along with sleep and collision coinciding.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    localparam int unsigned COND_W = 4;

    // Bit positions inside the condition vectors
    localparam int unsigned CB_START   = 0;
    localparam int unsigned CB_RESTART = 1;
    localparam int unsigned CB_STOP    = 2;
    localparam int unsigned CB_ACK     = 3;

    typedef struct packed {
        logic              irq;
        logic              abort;
        logic              rel;
        logic              tbf_clr;
        logic [COND_W-1:0] cond_clr;
        logic              sleep_prev;
    } resp_t;

    typedef struct packed {
        logic s;
        logic p;
        logic lost;
    } flags_t;

endpackage

// File: rtl/arb_line_watch.sv
module arb_line_watch #(
    parameter int unsigned HOLD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_det,
    output logic stop_det,
    output logic cmp_ok
);
    localparam int unsigned CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    typedef struct packed {
        logic          sda;
        logic          scl;
        logic [CW-1:0] cnt;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sda = sda_in;
        st_d.scl = scl_in;
        if (!scl_in || !en)
            st_d.cnt = '0;
        else if (st_q.cnt < HOLD_C)
            st_d.cnt = st_q.cnt + 1'b1;
        start_det = en && scl_in && st_q.scl && st_q.sda && !sda_in;
        stop_det  = en && scl_in && st_q.scl && !st_q.sda && sda_in;
        cmp_ok    = en && scl_in && (st_q.cnt >= HOLD_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{sda: 1'b1, scl: 1'b1, cnt: '0};
        else
            st_q <= st_d;
    end

    generate
        if (HOLD > 0) begin : g_skew_chk
            // R6
            skew_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.scl |-> !cmp_ok);
        end
    endgenerate

endmodule

// File: rtl/arb_flag_track.sv
module arb_flag_track
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic coll,
    output logic s_flag,
    output logic p_flag,
    output logic stop_irq
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (start_det) begin
            fl_d.s = 1'b1;
            fl_d.p = 1'b0;
        end else if (stop_det) begin
            fl_d.s = 1'b0;
            fl_d.p = 1'b1;
        end
        if (coll)
            fl_d.lost = 1'b1;
        else if (stop_det)
            fl_d.lost = 1'b0;
        stop_irq = stop_det && fl_q.lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fl_q <= '0;
        else
            fl_q <= fl_d;
    end

    assign s_flag = fl_q.s;
    assign p_flag = fl_q.p;

    // R2
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (s_flag && !p_flag));
    // R3
    stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (p_flag && !s_flag));
    // R9
    lost_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !fl_q.lost);

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
    import i2c_arb_pkg::*;
#(
    parameter int unsigned HOLD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              sda_drive,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic [COND_W-1:0] cond_busy,
    input  logic              sleep_req,
    input  logic              idle_req,
    input  logic              stop_in_idle,
    output logic              mst_irq,
    output logic              mst_abort,
    output logic              force_release,
    output logic              tbf_clr,
    output logic [COND_W-1:0] cond_clr,
    output logic              s_flag,
    output logic              p_flag,
    output logic              bus_free
);
    logic  halted, start_det, stop_det, cmp_ok, stop_irq;
    logic  active, coll, sleep_abort, any_abort;
    resp_t rs_d, rs_q;

    assign halted = idle_req && stop_in_idle;

    arb_line_watch #(.HOLD(HOLD)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (!halted),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .cmp_ok    (cmp_ok)
    );

    arb_flag_track u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .coll      (coll),
        .s_flag    (s_flag),
        .p_flag    (p_flag),
        .stop_irq  (stop_irq)
    );

    always_comb begin
        active      = tx_busy || (|cond_busy);
        coll        = cmp_ok && active && sda_drive && !sda_in;
        sleep_abort = sleep_req && !rs_q.sleep_prev && (active || rx_busy);
        any_abort   = coll || sleep_abort;

        rs_d            = '0;
        rs_d.sleep_prev = sleep_req;
        rs_d.irq        = coll || stop_irq;
        rs_d.abort      = any_abort;
        rs_d.rel        = any_abort;
        rs_d.tbf_clr    = any_abort && tx_busy;
        rs_d.cond_clr   = any_abort ? cond_busy : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rs_q <= '0;
        else
            rs_q <= rs_d;
    end

    assign mst_irq       = rs_q.irq;
    assign mst_abort     = rs_q.abort;
    assign force_release = rs_q.rel;
    assign tbf_clr       = rs_q.tbf_clr;
    assign cond_clr      = rs_q.cond_clr;
    assign bus_free      = p_flag || (!s_flag && !p_flag);

    // R7
    tbf_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbf_clr |-> (mst_abort && force_release));
    // R8
    cond_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_clr != '0) |-> mst_abort);
    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_flag && p_flag));
    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(s_flag) && $stable(p_flag) && !mst_irq));
    // R10
    sleep_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && $past(sleep_req) && !cmp_ok) |=> !mst_abort);

endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
    localparam int unsigned HOLD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda = 1'b1, scl = 1'b1, drv = 1'b1, tx = 1'b0, rx = 1'b0;
    logic [3:0] cond = '0;
    logic slp = 1'b0, idl = 1'b0, sid = 1'b0;
    logic irq, abort, rel, tbf, s_f, p_f, free;
    logic [3:0] cclr;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model state
    logic m_sda = 1'b1, m_scl = 1'b1, m_s = 1'b0, m_p = 1'b0, m_lost = 1'b0, m_slp = 1'b0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    i2c_arb_monitor #(.HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl), .sda_drive(drv),
        .tx_busy(tx), .rx_busy(rx), .cond_busy(cond), .sleep_req(slp),
        .idle_req(idl), .stop_in_idle(sid), .mst_irq(irq), .mst_abort(abort),
        .force_release(rel), .tbf_clr(tbf), .cond_clr(cclr), .s_flag(s_f),
        .p_flag(p_f), .bus_free(free)
    );

    function automatic logic [10:0] outs();
        return {irq, abort, rel, tbf, cclr, s_f, p_f, free};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [10:0] act, input logic [10:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock: predict from requirements, advance, compare all outputs.
    task automatic cyc(input string req);
        logic en, st, sp, cmp, act, coll, sab, ab, ns, np, e_irq;
        logic [10:0] e;
        en    = !(idl && sid);
        st    = en && scl && m_scl && m_sda && !sda;
        sp    = en && scl && m_scl && !m_sda && sda;
        cmp   = en && scl && (m_cnt >= HOLD);
        act   = tx || (|cond);
        coll  = cmp && act && drv && !sda;
        sab   = slp && !m_slp && (act || rx);
        ab    = coll || sab;
        e_irq = coll || (sp && m_lost);
        ns    = st ? 1'b1 : (sp ? 1'b0 : m_s);
        np    = sp ? 1'b1 : (st ? 1'b0 : m_p);
        e     = {e_irq, ab, ab, ab && tx, ab ? cond : 4'b0, ns, np, np || (!ns && !np)};
        m_lost = coll ? 1'b1 : (sp ? 1'b0 : m_lost);
        m_cnt  = (!scl || !en) ? 0 : ((m_cnt < HOLD) ? m_cnt + 1 : m_cnt);
        m_s = ns; m_p = np; m_sda = sda; m_scl = scl; m_slp = slp;
        @(negedge clk);
        chk(outs() === e, req, outs(), e);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic s_prev;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() === 11'b0000_0000_001, "R1 reset", outs(), 11'b0000_0000_001);

        // R2 start
        sda = 0; cyc("R2");
        chk(s_f && !p_f && !free, "R2 start sets S / R4 busy", outs(), 11'b0000_0000_100);
        // R3 stop
        scl = 0; cyc("R3"); scl = 1; cyc("R3"); sda = 1; cyc("R3");
        chk(p_f && !s_f && free, "R3 stop sets P / R4 free", outs(), 11'b0000_0000_011);

        // R5/R6/R7 collision during transmit
        tx = 1; drv = 1; scl = 0; cyc("R5"); sda = 0; cyc("R5");
        scl = 1; cyc("R6");
        chk(!abort && !irq, "R6 no compare on first high sample", outs(), 11'b0);
        cyc("R5");
        chk(irq && abort && rel && tbf && cclr == 0, "R5 R7 collision response", outs(), 11'b1111_0000_011);
        tx = 0; cyc("R12");
        chk(!abort && !irq, "R12 idle master no collision", outs(), 11'b0);
        // R9 stop after loss
        sda = 1; cyc("R9");
        chk(irq && !abort && p_f, "R9 stop irq after loss", outs(), 11'b1000_0000_011);
        scl = 0; cyc("R9"); sda = 0; cyc("R9"); scl = 1; cyc("R9"); sda = 1; cyc("R9");
        chk(!irq, "R9 second stop no irq", outs(), 11'b0000_0000_011);

        // R8 collision during a Stop condition
        cond = 4'b0100; scl = 0; cyc("R8"); sda = 0; cyc("R8"); scl = 1; cyc("R8"); cyc("R8");
        chk(abort && cclr == 4'b0100 && !tbf, "R8 cond clear copy", {7'b0, cclr}, 11'b100);
        cond = 0; cyc("R8");

        // R12 driving low is not compared
        tx = 1; drv = 0; cyc("R12"); cyc("R12");
        chk(!abort, "R12 drive low no collision", outs(), 11'b0);
        tx = 0; drv = 1; sda = 1; cyc("R12"); cyc("R12");

        // corner: collision and Start in the same cycle
        tx = 1; sda = 0; cyc("R5 R2 overlap");
        chk(abort && s_f && !free, "R5 R2 collision with start", outs(), 11'b1111_0000_100);
        tx = 0; sda = 1; cyc("R3"); cyc("R3");

        // R10 sleep abort
        rx = 1; slp = 1; cyc("R10");
        chk(abort && rel && !irq && !tbf, "R10 sleep abort", outs(), 11'b0110_0000_011);
        cyc("R10");
        chk(!abort, "R10 held sleep no repeat", outs(), 11'b0);
        rx = 0; slp = 0; cyc("R10");

        // R11 halt in idle
        idl = 1; sid = 1; s_prev = s_f; sda = 0; cyc("R11");
        chk(s_f == s_prev, "R11 halted no start", {10'b0, s_f}, {10'b0, s_prev});
        sda = 1; cyc("R11"); sid = 0; sda = 0; cyc("R11");
        chk(s_f, "R11 idle without stop-in-idle detects", {10'b0, s_f}, 11'b1);
        idl = 0; sda = 1; cyc("R11");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3) == 0) scl = ~scl;
            if ($urandom_range(3) == 0) sda = ~sda;
            drv = ($urandom_range(3) != 0);
            if ($urandom_range(15) == 0) tx = ~tx;
            if ($urandom_range(15) == 0) rx = ~rx;
            if ($urandom_range(15) == 0) cond = 4'($urandom_range(15)) & 4'($urandom_range(15));
            if ($urandom_range(31) == 0) slp = ~slp;
            if ($urandom_range(31) == 0) idl = ~idl;
            if ($urandom_range(63) == 0) sid = ~sid;
            cyc("R5 R9 R10 R11 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule